// File: doc/BRIEF.md
# Display-Side Nibble Bus Receiver

This block models the receiving end of a character-display command bus. A host presents a data nibble and a register-select bit, then pulses a strobe. The receiver runs in one of two widths. In the wide (8-bit) width, each strobe is a whole command. Only the upper four data lines exist on this bus, so the low half of the byte reads as zero. In the narrow (4-bit) width, two strobes build one byte: the high half arrives first, then the low half.

The receiver keeps a nibble-phase bit that records whether half a byte is pending. If the host restarts after sending only the high half of a byte, the receiver takes the next nibble as the low half, and the pairing stays shifted. A function-set command can be recognised in either phase. The host's restart sequence of nibbles 0x3, 0x3, 0x3, 0x2 therefore ends in the narrow width with no half byte pending, whatever phase and width it started from.

Each completed byte is reported once, together with its register-select tag. Width changes are flagged with a pulse.

Top module: `lcdrx_nibble_rx`

## Requirements
- R1: After synchronous reset the receiver is in the wide width (`mode_wide`=1), with `phase_half`=0, `byte_vld`=0 and `mode_chg`=0.
- R2: In the wide width, each strobe completes a byte whose upper half is `bus_nib` and whose lower half is 0000, tagged with `rs_in` of that strobe. `phase_half` stays 0.
- R3: In the narrow width, two strobes form one byte, with the first nibble as bits 7:4 and the second as bits 3:0. After the first strobe `phase_half`=1 and no byte is reported.
- R4: In the narrow width, the completed byte carries the `rs_in` value sampled with its first nibble.
- R5: A completed byte with rs=0 and bits 7:5 = 001 is a function-set command. Bit 4 = 1 selects the wide width and bit 4 = 0 selects the narrow width. The width changes on the same edge that completes the byte. A byte with rs=1 never changes the width.
- R6: `mode_chg` pulses for one cycle, together with `byte_vld`, only when a function-set command changes the width.
- R7: If the host abandons a byte after its first nibble, the next nibble completes that byte as its low half. For example, 0x8 followed by 0x3 yields 0x83.
- R8: The nibble sequence 0x3, 0x3, 0x3, 0x2 (rs=0) leaves the receiver in the narrow width with `phase_half`=0. This holds from the wide width, from an aligned narrow width and from a narrow width with a half byte pending.
- R9: `byte_vld` is high for exactly one cycle per completed byte, in the cycle after the completing strobe, and never without a strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nib_stb | input | 1 | One-cycle strobe: sample `bus_nib` and `rs_in` |
| rs_in | input | 1 | Register-select: 0 command, 1 data |
| bus_nib | input | 4 | Data nibble on the upper bus lines |
| byte_vld | output | 1 | One-cycle pulse when a byte completes |
| byte_data | output | 8 | Assembled byte |
| byte_rs | output | 1 | Register-select tag of the byte |
| mode_wide | output | 1 | 1 wide (8-bit) width, 0 narrow (4-bit) width |
| mode_chg | output | 1 | One-cycle pulse when the width changes |
| phase_half | output | 1 | 1 while a high nibble waits for its low half |

## Verification
The assertions assume that `nib_stb` is a single-cycle pulse sampled on the clock, with `bus_nib` and `rs_in` valid in that cycle. Under that assumption, one strobe causes one phase step and at most one completed byte. The bench drives every strobe as a one-cycle pulse followed by at least one idle cycle, so consecutive strobes never merge. It predicts the width and the phase from the requirements, then covers three cases: aligned restarts, restarts after a half byte, and restarts from the wide width.

// File: rtl/lcdrx_pkg.sv
// Package: shared types and command codes for the nibble receiver.
// Assumes the function-set tag sits in the top three bits of the byte.
package lcdrx_pkg;
    typedef enum logic {
        PH_HIGH = 1'b0,
        PH_LOW  = 1'b1
    } nib_phase_e;

    localparam logic [2:0] FSET_TAG = 3'b001;
endpackage

// File: rtl/lcdrx_assembler.sv
// Module: lcdrx_assembler
// Tracks the nibble phase and forms a completed byte combinationally on the
// strobe that finishes it. Assumes nib_stb is a single-cycle pulse.
module lcdrx_assembler
    import lcdrx_pkg::*;
#(
    parameter int NIB_W  = 4,
    localparam int BYTE_W = 2 * NIB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nib_stb,
    input  logic              rs_in,
    input  logic [NIB_W-1:0]  bus_nib,
    input  logic              wide,
    output logic              cmp_vld,
    output logic [BYTE_W-1:0] cmp_byte,
    output logic              cmp_rs,
    output logic              phase_half
);
    nib_phase_e       phase_q;
    logic [NIB_W-1:0] hi_q;
    logic             rs_q;

    // Purpose: form the byte completed by this strobe, if any.
    always_comb begin
        cmp_vld  = 1'b0;
        cmp_byte = '0;
        cmp_rs   = 1'b0;
        if (nib_stb) begin
            if (wide) begin
                cmp_vld  = 1'b1;
                cmp_byte = {bus_nib, {NIB_W{1'b0}}};
                cmp_rs   = rs_in;
            end else if (phase_q == PH_LOW) begin
                cmp_vld  = 1'b1;
                cmp_byte = {hi_q, bus_nib};
                cmp_rs   = rs_q;
            end
        end
    end

    // Purpose: advance the nibble phase and hold the pending high half.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_HIGH;
            hi_q    <= '0;
            rs_q    <= 1'b0;
        end else if (nib_stb) begin
            if (wide) begin
                phase_q <= PH_HIGH;
            end else if (phase_q == PH_HIGH) begin
                phase_q <= PH_LOW;
                hi_q    <= bus_nib;
                rs_q    <= rs_in;
            end else begin
                phase_q <= PH_HIGH;
            end
        end
    end

    assign phase_half = (phase_q == PH_LOW);
endmodule

// File: rtl/lcdrx_mode_ctl.sv
// Module: lcdrx_mode_ctl
// Decodes function-set commands from completed bytes and holds the width.
// Assumes the high nibble of a completed byte is presented with cmp_vld.
module lcdrx_mode_ctl
    import lcdrx_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_vld,
    input  logic             cmp_rs,
    input  logic [NIB_W-1:0] cmp_hi,
    output logic             wide,
    output logic             chg_pulse
);
    logic is_fset;
    logic req_wide;

    // Purpose: recognise a function-set command and its width request.
    always_comb begin
        is_fset  = cmp_vld && !cmp_rs && (cmp_hi[NIB_W-1 -: 3] == FSET_TAG);
        req_wide = cmp_hi[NIB_W-4];
    end

    // Purpose: update the width and flag an actual change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wide      <= 1'b1;
            chg_pulse <= 1'b0;
        end else begin
            chg_pulse <= is_fset && (req_wide != wide);
            if (is_fset) begin
                wide <= req_wide;
            end
        end
    end
endmodule

// File: rtl/lcdrx_out_stage.sv
// Module: lcdrx_out_stage
// Registers the completed byte and its tag and gives a one-cycle valid.
// Assumes at most one completion per cycle.
module lcdrx_out_stage #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_vld,
    input  logic [BYTE_W-1:0] cmp_byte,
    input  logic              cmp_rs,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_data,
    output logic              byte_rs
);
    // Purpose: register the result and hold the data between bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_vld  <= 1'b0;
            byte_data <= '0;
            byte_rs   <= 1'b0;
        end else begin
            byte_vld <= cmp_vld;
            if (cmp_vld) begin
                byte_data <= cmp_byte;
                byte_rs   <= cmp_rs;
            end
        end
    end
endmodule

// File: rtl/lcdrx_nibble_rx.sv
// Module: lcdrx_nibble_rx (top)
// Display-side receiver: assembles strobed nibbles into bytes according to
// the current width and applies function-set width changes.
// Assumes nib_stb is a single-cycle synchronous pulse.
module lcdrx_nibble_rx #(
    parameter int NIB_W  = 4,
    localparam int BYTE_W = 2 * NIB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nib_stb,
    input  logic              rs_in,
    input  logic [NIB_W-1:0]  bus_nib,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_data,
    output logic              byte_rs,
    output logic              mode_wide,
    output logic              mode_chg,
    output logic              phase_half
);
    logic              cmp_vld;
    logic [BYTE_W-1:0] cmp_byte;
    logic              cmp_rs;

    lcdrx_assembler #(.NIB_W(NIB_W)) u_asm (
        .clk        (clk),
        .rst_n      (rst_n),
        .nib_stb    (nib_stb),
        .rs_in      (rs_in),
        .bus_nib    (bus_nib),
        .wide       (mode_wide),
        .cmp_vld    (cmp_vld),
        .cmp_byte   (cmp_byte),
        .cmp_rs     (cmp_rs),
        .phase_half (phase_half)
    );

    lcdrx_mode_ctl #(.NIB_W(NIB_W)) u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmp_vld   (cmp_vld),
        .cmp_rs    (cmp_rs),
        .cmp_hi    (cmp_byte[BYTE_W-1 -: NIB_W]),
        .wide      (mode_wide),
        .chg_pulse (mode_chg)
    );

    lcdrx_out_stage #(.BYTE_W(BYTE_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmp_vld   (cmp_vld),
        .cmp_byte  (cmp_byte),
        .cmp_rs    (cmp_rs),
        .byte_vld  (byte_vld),
        .byte_data (byte_data),
        .byte_rs   (byte_rs)
    );
endmodule

// File: rtl/lcdrx_nibble_rx_chk.sv
// Module: lcdrx_nibble_rx_chk
// Port-level properties of the receiver, bound to the top module.
// Assumes nib_stb is a single-cycle pulse.
module lcdrx_nibble_rx_chk #(
    parameter int NIB_W  = 4,
    localparam int BYTE_W = 2 * NIB_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              nib_stb,
    input logic              rs_in,
    input logic [NIB_W-1:0]  bus_nib,
    input logic              byte_vld,
    input logic [BYTE_W-1:0] byte_data,
    input logic              byte_rs,
    input logic              mode_wide,
    input logic              mode_chg,
    input logic              phase_half
);
    // R2
    wide_full_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nib_stb && mode_wide) |=> (byte_vld && byte_data[NIB_W-1:0] == '0 && !phase_half));

    // R2
    wide_no_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wide |-> !phase_half);

    // R3
    first_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nib_stb && !mode_wide && !phase_half) |=> (phase_half && !byte_vld));

    // R3
    second_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nib_stb && !mode_wide && phase_half) |=> (byte_vld && !phase_half));

    // R5
    fset_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && !byte_rs && byte_data[BYTE_W-1 -: 3] == 3'b001)
            |-> (mode_wide == byte_data[BYTE_W-4]));

    // R5
    width_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_vld |-> $stable(mode_wide));

    // R6
    chg_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |-> (byte_vld && !byte_rs && mode_wide != $past(mode_wide)));

    // R9
    vld_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |-> $past(nib_stb));

    // R9
    stb_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nib_stb |-> !$isunknown({rs_in, bus_nib}));
endmodule

bind lcdrx_nibble_rx lcdrx_nibble_rx_chk #(.NIB_W(NIB_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .nib_stb    (nib_stb),
    .rs_in      (rs_in),
    .bus_nib    (bus_nib),
    .byte_vld   (byte_vld),
    .byte_data  (byte_data),
    .byte_rs    (byte_rs),
    .mode_wide  (mode_wide),
    .mode_chg   (mode_chg),
    .phase_half (phase_half)
);

// File: tb/sim_lcdrx_nibble_rx.sv
`timescale 1ns/1ps
module sim_lcdrx_nibble_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       nib_stb = 1'b0;
    logic       rs_in = 1'b0;
    logic [3:0] bus_nib = 4'h0;
    logic       byte_vld;
    logic [7:0] byte_data;
    logic       byte_rs;
    logic       mode_wide;
    logic       mode_chg;
    logic       phase_half;

    int n_chk = 0;
    int n_err = 0;
    logic [8:0] exp_q[$];

    // bench model of the receiver state, from the requirements
    bit       m_wide = 1'b1;
    bit       m_half = 1'b0;
    bit       m_chg  = 1'b0;
    bit       m_rs   = 1'b0;
    bit [3:0] m_hi   = 4'h0;

    always #10 clk = ~clk;

    lcdrx_nibble_rx u0 (
        .clk(clk), .rst_n(rst_n), .nib_stb(nib_stb), .rs_in(rs_in),
        .bus_nib(bus_nib), .byte_vld(byte_vld), .byte_data(byte_data),
        .byte_rs(byte_rs), .mode_wide(mode_wide), .mode_chg(mode_chg),
        .phase_half(phase_half)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // monitor: pop and compare each reported byte (R2 R3 R4 R9)
    always @(negedge clk) begin
        if (rst_n && byte_vld) begin
            if (exp_q.size() == 0) begin
                chk("R9", "unexpected byte", {23'd0, byte_rs, byte_data}, 32'h1ff);
            end else begin
                chk("R2/R3/R4", "byte", {23'd0, byte_rs, byte_data},
                    {23'd0, exp_q.pop_front()});
            end
        end
    end

    // driver: one strobe, model update, expected byte pushed
    task automatic send_nib(input bit rs, input bit [3:0] n);
        bit       done;
        bit [7:0] b;
        bit       brs;
        @(negedge clk);
        rs_in = rs; bus_nib = n; nib_stb = 1'b1;
        done = 1'b0; b = 8'h00; brs = 1'b0; m_chg = 1'b0;
        if (m_wide) begin
            done = 1'b1; b = {n, 4'h0}; brs = rs; m_half = 1'b0;
        end else if (!m_half) begin
            m_hi = n; m_rs = rs; m_half = 1'b1;
        end else begin
            done = 1'b1; b = {m_hi, n}; brs = m_rs; m_half = 1'b0;
        end
        if (done) begin
            exp_q.push_back({brs, b});
            if (!brs && b[7:5] == 3'b001) begin
                m_chg  = (b[4] != m_wide);
                m_wide = b[4];
            end
        end
        @(negedge clk);
        nib_stb = 1'b0;
    endtask

    task automatic chk_state(input string req);
        chk(req, "mode_wide", {31'd0, mode_wide}, {31'd0, m_wide});
        chk(req, "phase_half", {31'd0, phase_half}, {31'd0, m_half});
        chk(req, "mode_chg", {31'd0, mode_chg}, {31'd0, m_chg});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; nib_stb = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_wide = 1'b1; m_half = 1'b0; m_chg = 1'b0;
        exp_q.delete();
    endtask

    task automatic restart_seq();
        send_nib(1'b0, 4'h3);
        send_nib(1'b0, 4'h3);
        send_nib(1'b0, 4'h3);
        send_nib(1'b0, 4'h2);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        // R1 reset state
        chk("R1", "mode_wide", {31'd0, mode_wide}, 32'd1);
        chk("R1", "phase_half", {31'd0, phase_half}, 32'd0);
        chk("R1", "byte_vld", {31'd0, byte_vld}, 32'd0);
        chk("R1", "mode_chg", {31'd0, mode_chg}, 32'd0);

        // R2 wide width: data and command strobes
        send_nib(1'b1, 4'hA); chk_state("R2");
        chk("R2", "low half zero", {28'd0, byte_data[3:0]}, 32'd0);
        send_nib(1'b0, 4'h1); chk_state("R2");

        // R5 R6 switch to narrow width
        send_nib(1'b0, 4'h2); chk_state("R5");
        chk("R6", "chg pulse", {31'd0, mode_chg}, 32'd1);
        @(negedge clk);
        chk("R6", "chg one cycle", {31'd0, mode_chg}, 32'd0);
        chk("R9", "vld one cycle", {31'd0, byte_vld}, 32'd0);

        // R3 R4 narrow width: rs from first nibble
        send_nib(1'b1, 4'h4); chk_state("R3");
        chk("R3", "no byte on first half", {31'd0, byte_vld}, 32'd0);
        send_nib(1'b0, 4'h1); chk_state("R4");
        chk("R4", "rs of first nibble", {31'd0, byte_rs}, 32'd1);

        // R5 rs=1 byte 0x38 does not change width
        send_nib(1'b1, 4'h3); send_nib(1'b1, 4'h8); chk_state("R5");
        // R6 function set to same width: no pulse
        send_nib(1'b0, 4'h2); send_nib(1'b0, 4'h8); chk_state("R6");

        // R7 abandoned byte, short restart stays shifted
        send_nib(1'b0, 4'h8);
        send_nib(1'b0, 4'h3); chk_state("R7");
        chk("R7", "shifted byte", {24'd0, byte_data}, 32'h83);
        send_nib(1'b0, 4'h2); chk_state("R7");
        chk("R7", "still half", {31'd0, phase_half}, 32'd1);
        send_nib(1'b0, 4'h0); chk_state("R7");

        // R8 from narrow width with half pending
        send_nib(1'b0, 4'h8);
        restart_seq(); chk_state("R8");
        chk("R8", "narrow after half start", {30'd0, mode_wide, phase_half}, 32'd0);

        // R8 from aligned narrow width
        restart_seq(); chk_state("R8");
        chk("R8", "narrow after aligned start", {30'd0, mode_wide, phase_half}, 32'd0);

        // R8 from wide width after reset
        do_reset();
        restart_seq(); chk_state("R8");
        chk("R8", "narrow after wide start", {30'd0, mode_wide, phase_half}, 32'd0);

        repeat (3) @(negedge clk);
        chk("R9", "leftover expected bytes", exp_q.size(), 32'd0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule